// File: doc/BRIEF.md
# Overlapping Memory Region Bus Router

This block sits between a CPU bus and two memories: an internal memory and an external memory bus. Their address maps may overlap, and the internal memory takes precedence wherever they do. The router accepts one CPU access at a time. It sorts the access into one of three targets: external only, internal only, or both. It drives the matching memory strobes from registered copies of the address and data, and it returns read data to the CPU from the memory that owns the address.

Inside the overlap window a read still runs a complete external read cycle, with the address and read strobe driven for the full duration. Only the internal data is handed back to the CPU. A write inside the window goes to both memories with the same data. Any access that involves the external bus is stretched by a wait count taken from the `wait_states` input when the access starts. Accesses that touch only internal memory always finish in a single cycle.

The address window of the internal memory, and the part of that window that is also mapped externally, are parameters. Every address outside the internal window goes to the external bus.

Top module: `ovl_bus_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cpu_ready`, `int_rd`, `int_wr`, `ext_rd` and `ext_wr` are all 0.
- R2: An address below `INT_BASE` or above `INT_LAST` is an external-only access. Only `ext_rd`/`ext_wr` are asserted, `int_rd`/`int_wr` stay 0, only external memory is written, and a read returns `ext_rdata`.
- R3: An address from `INT_BASE` to `INT_LAST` that lies outside `OVL_BASE`..`OVL_LAST` is an internal-only access. No external strobe is asserted. `cpu_ready` is 1 in the first cycle after the request is sampled, whatever `wait_states` holds.
- R4: A read at an address from `OVL_BASE` to `OVL_LAST` asserts `ext_rd` with `ext_addr` equal to the CPU address for the whole access. `cpu_rdata` still equals `int_rdata`.
- R5: A write at an address from `OVL_BASE` to `OVL_LAST` asserts `ext_wr` and `int_wr` together with equal write data, so both memories hold the written value afterwards.
- R6: An access that involves the external bus lasts `W+1` cycles, where `W` (0..3) is the value of `wait_states` in the cycle the request is sampled. `cpu_ready` is 0 for the first `W` cycles and 1 in the last. Changing `wait_states` during the access has no effect on it.
- R7: The read-data select is registered with the address. In the ready cycle, `cpu_rdata` is the content of the memory selected for that access at that address.
- R8: While an external access waits, `ext_addr` and `ext_wdata` stay stable.
- R9: `cpu_ready` is 1 for exactly one cycle per access. A request is taken only while idle, so `cpu_ready` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU address, held until ready |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | DATA_W | CPU write data |
| wait_states | input | WAIT_W | External wait count, sampled when a request is taken |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| cpu_ready | output | 1 | Access completes in this cycle |
| int_addr | output | ADDR_W | Internal memory address |
| int_rd | output | 1 | Internal read strobe |
| int_wr | output | 1 | Internal write strobe (ready cycle only) |
| int_wdata | output | DATA_W | Internal write data |
| int_rdata | input | DATA_W | Internal read data (asynchronous) |
| ext_addr | output | ADDR_W | External bus address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | DATA_W | External write data |
| ext_rdata | input | DATA_W | External read data (asynchronous) |

## Verification
A request placed on the bus at a falling edge is taken at the next rising edge. The strobes appear at the falling edge after that. `cpu_ready` is due on the first such falling edge for internal-only accesses and on the `(W+1)`-th for accesses that involve the external bus. The bench samples every falling edge up to `cpu_ready`, so it counts the access length exactly and also records which strobes were seen. It reads `cpu_rdata` at the ready falling edge. It checks memory contents and the drop of `cpu_ready` one falling edge later, after the write edge has passed. It also sweeps every address of a 6-bit map against every wait count, and changes `wait_states` in the middle of each access.

// File: rtl/ovl_bus_pkg.sv
// Package: shared types for the overlapping-region bus router.
// Assumes: nothing beyond IEEE 1800-2017.
package ovl_bus_pkg;

    // Where an access is routed.
    typedef enum logic [1:0] {
        TGT_EXT  = 2'd0,
        TGT_INT  = 2'd1,
        TGT_BOTH = 2'd2
    } tgt_e;

    // Sequencer state.
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } seq_state_e;

    // True when the target uses the external bus.
    function automatic logic tgt_uses_ext(tgt_e t);
        return (t != TGT_INT);
    endfunction

    // True when the target uses the internal memory.
    function automatic logic tgt_uses_int(tgt_e t);
        return (t != TGT_EXT);
    endfunction

endpackage

// File: rtl/ovl_region_decoder.sv
// Module: ovl_region_decoder
// Classifies an address into external-only, internal-only or both.
// Assumes: INT_BASE <= OVL_BASE <= OVL_LAST <= INT_LAST; purely combinational.
module ovl_region_decoder
    import ovl_bus_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] INT_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF,
    parameter logic [ADDR_W-1:0] OVL_BASE = 16'h0800,
    parameter logic [ADDR_W-1:0] OVL_LAST = 16'h0FFF
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt
);

    logic in_int;
    logic in_ovl;

    // Window compares.
    always_comb begin
        in_int = (addr >= INT_BASE) && (addr <= INT_LAST);
        in_ovl = (addr >= OVL_BASE) && (addr <= OVL_LAST);
    end

    // Internal memory wins; external mapping inside it means both.
    always_comb begin
        if (!in_int)
            tgt = TGT_EXT;
        else if (in_ovl)
            tgt = TGT_BOTH;
        else
            tgt = TGT_INT;
    end

endmodule

// File: rtl/ovl_wait_counter.sv
// Module: ovl_wait_counter
// Down-counter for external wait states; loads a value, counts to zero.
// Assumes: load and count never both needed in the same cycle.
module ovl_wait_counter #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              zero
);

    logic [WAIT_W-1:0] cnt_q;

    // Load on accept, decrement while running and non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Zero flag.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/ovl_access_sequencer.sv
// Module: ovl_access_sequencer
// Accepts one CPU access while idle, latches address, data, direction
// and target, and holds them until the wait count expires.
// Assumes: CPU holds its request until it sees ready.
module ovl_access_sequencer
    import ovl_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  tgt_e              req_tgt,
    input  logic [WAIT_W-1:0] req_waits,
    output logic              busy,
    output logic              last,
    output logic              acc_wr,
    output tgt_e              acc_tgt,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);

    seq_state_e        state_q;
    logic              accept;
    logic              cnt_zero;
    logic [WAIT_W-1:0] load_val;

    // Accept only from idle.
    always_comb accept = (state_q == SQ_IDLE) && (req_rd || req_wr);

    // Internal-only accesses never wait.
    always_comb load_val = tgt_uses_ext(req_tgt) ? req_waits : '0;

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else if (accept)
            state_q <= SQ_BUSY;
        else if ((state_q == SQ_BUSY) && cnt_zero)
            state_q <= SQ_IDLE;
    end

    // Latch the access attributes at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_wdata <= '0;
            acc_wr    <= 1'b0;
            acc_tgt   <= TGT_EXT;
        end else if (accept) begin
            acc_addr  <= req_addr;
            acc_wdata <= req_wdata;
            acc_wr    <= req_wr;
            acc_tgt   <= req_tgt;
        end
    end

    ovl_wait_counter #(
        .WAIT_W (WAIT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .run      (busy),
        .zero     (cnt_zero)
    );

    // Status outputs.
    always_comb begin
        busy = (state_q == SQ_BUSY);
        last = busy && cnt_zero;
    end

endmodule

// File: rtl/ovl_return_mux.sv
// Module: ovl_return_mux
// Selects read data for the CPU from the latched target.
// Assumes: memories return data combinationally from the driven address.
module ovl_return_mux
    import ovl_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  tgt_e              sel_tgt,
    input  logic [DATA_W-1:0] int_data,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] cpu_data
);

    // Internal memory owns any address it maps.
    always_comb cpu_data = tgt_uses_int(sel_tgt) ? int_data : ext_data;

endmodule

// File: rtl/ovl_bus_router.sv
// Module: ovl_bus_router (top)
// Routes CPU accesses to internal memory, external bus or both, and
// adds external wait states.
// Assumes: one outstanding access; CPU holds request until ready.
module ovl_bus_router
    import ovl_bus_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter int              WAIT_W   = 2,
    parameter logic [ADDR_W-1:0] INT_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF,
    parameter logic [ADDR_W-1:0] OVL_BASE = 16'h0800,
    parameter logic [ADDR_W-1:0] OVL_LAST = 16'h0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [WAIT_W-1:0] wait_states,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [ADDR_W-1:0] int_addr,
    output logic              int_rd,
    output logic              int_wr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);

    tgt_e              req_tgt;
    tgt_e              acc_tgt;
    logic              busy;
    logic              last;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;

    ovl_region_decoder #(
        .ADDR_W   (ADDR_W),
        .INT_BASE (INT_BASE),
        .INT_LAST (INT_LAST),
        .OVL_BASE (OVL_BASE),
        .OVL_LAST (OVL_LAST)
    ) u_decode (
        .addr (cpu_addr),
        .tgt  (req_tgt)
    );

    ovl_access_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (cpu_addr),
        .req_rd    (cpu_rd),
        .req_wr    (cpu_wr),
        .req_wdata (cpu_wdata),
        .req_tgt   (req_tgt),
        .req_waits (wait_states),
        .busy      (busy),
        .last      (last),
        .acc_wr    (acc_wr),
        .acc_tgt   (acc_tgt),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata)
    );

    ovl_return_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .sel_tgt  (acc_tgt),
        .int_data (int_rdata),
        .ext_data (ext_rdata),
        .cpu_data (cpu_rdata)
    );

    // Memory-side strobes from latched access.
    always_comb begin
        int_addr  = acc_addr;
        int_wdata = acc_wdata;
        ext_addr  = acc_addr;
        ext_wdata = acc_wdata;
        int_rd    = busy && !acc_wr && tgt_uses_int(acc_tgt);
        int_wr    = last &&  acc_wr && tgt_uses_int(acc_tgt);
        ext_rd    = busy && !acc_wr && tgt_uses_ext(acc_tgt);
        ext_wr    = busy &&  acc_wr && tgt_uses_ext(acc_tgt);
        cpu_ready = last;
    end

endmodule

// File: rtl/ovl_bus_router_chk.sv
// Module: ovl_bus_router_chk
// Assertion checker bound to ovl_bus_router.
// Assumes: same parameters as the bound instance.
module ovl_bus_router_chk #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] INT_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF,
    parameter logic [ADDR_W-1:0] OVL_BASE = 16'h0800,
    parameter logic [ADDR_W-1:0] OVL_LAST = 16'h0FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [ADDR_W-1:0] int_addr,
    input logic              int_rd,
    input logic              int_wr,
    input logic [DATA_W-1:0] int_wdata,
    input logic [DATA_W-1:0] int_rdata,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic [DATA_W-1:0] ext_wdata
);

    logic ext_in_int;
    logic ext_any;
    logic int_any;

    // Address class of the external-side address.
    always_comb begin
        ext_in_int = (ext_addr >= INT_BASE) && (ext_addr <= INT_LAST);
        ext_any    = ext_rd || ext_wr;
        int_any    = int_rd || int_wr;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!cpu_ready && !int_any && !ext_any));

    // R2
    ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_any && !ext_in_int) |-> !int_any);

    // R3
    int_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_any && !ext_any) |-> cpu_ready);

    // R4
    ovl_read_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ext_rd && ext_in_int) |-> (int_rd && cpu_rdata == int_rdata));

    // R5
    ovl_write_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ext_wr && ext_in_int) |-> (int_wr && int_wdata == ext_wdata
                                                 && int_addr == ext_addr));

    // R6
    ext_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_any && !cpu_ready) |=> ext_any);

    // R8
    ext_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_any && !cpu_ready) |=> ($stable(ext_addr) && $stable(ext_wdata)));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

endmodule

bind ovl_bus_router ovl_bus_router_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .INT_BASE (INT_BASE),
    .INT_LAST (INT_LAST),
    .OVL_BASE (OVL_BASE),
    .OVL_LAST (OVL_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .int_addr  (int_addr),
    .int_rd    (int_rd),
    .int_wr    (int_wr),
    .int_wdata (int_wdata),
    .int_rdata (int_rdata),
    .ext_addr  (ext_addr),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ext_wdata (ext_wdata)
);

// File: tb/ovl_bus_router_bench.sv
// Bench: sweeps every address of a 6-bit map against every wait count.
module ovl_bus_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int WW = 2;
    localparam int IB = 16;
    localparam int IL = 47;
    localparam int OB = 32;
    localparam int OL = 47;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [WW-1:0] wait_states = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic [AW-1:0] int_addr;
    logic          int_rd;
    logic          int_wr;
    logic [DW-1:0] int_wdata;
    logic [DW-1:0] int_rdata;
    logic [AW-1:0] ext_addr;
    logic          ext_rd;
    logic          ext_wr;
    logic [DW-1:0] ext_wdata;
    logic [DW-1:0] ext_rdata;

    logic [DW-1:0] int_mem [DEPTH];
    logic [DW-1:0] ext_mem [DEPTH];
    logic [DW-1:0] exp_int [DEPTH];
    logic [DW-1:0] exp_ext [DEPTH];
    logic          preload = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_bus_router #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .WAIT_W   (WW),
        .INT_BASE (AW'(IB)),
        .INT_LAST (AW'(IL)),
        .OVL_BASE (AW'(OB)),
        .OVL_LAST (AW'(OL))
    ) u_ovl_bus_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .cpu_wdata   (cpu_wdata),
        .wait_states (wait_states),
        .cpu_rdata   (cpu_rdata),
        .cpu_ready   (cpu_ready),
        .int_addr    (int_addr),
        .int_rd      (int_rd),
        .int_wr      (int_wr),
        .int_wdata   (int_wdata),
        .int_rdata   (int_rdata),
        .ext_addr    (ext_addr),
        .ext_rd      (ext_rd),
        .ext_wr      (ext_wr),
        .ext_wdata   (ext_wdata),
        .ext_rdata   (ext_rdata)
    );

    // Memory models: asynchronous read, write on rising edge.
    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < DEPTH; i++) begin
                int_mem[i] <= DW'(i) ^ 8'hA5;
                ext_mem[i] <= DW'(i) ^ 8'h5A;
            end
        end else begin
            if (int_wr) int_mem[int_addr] <= int_wdata;
            if (ext_wr) ext_mem[ext_addr] <= ext_wdata;
        end
    end
    assign int_rdata = int_mem[int_addr];
    assign ext_rdata = ext_mem[ext_addr];

    // Target class: 0 external, 1 internal, 2 both.
    function automatic int cls(int a);
        if (a < IB || a > IL) return 0;
        if (a >= OB && a <= OL) return 2;
        return 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_access(bit is_wr, int a, int d, int w);
        int n = 0;
        bit done = 1'b0;
        bit saw_ext = 1'b0;
        bit saw_int = 1'b0;
        int got = 0;
        int c = cls(a);
        int exp_n = (c == 1) ? 1 : w + 1;
        @(negedge clk);
        cpu_addr = AW'(a);
        cpu_rd = !is_wr;
        cpu_wr = is_wr;
        cpu_wdata = DW'(d);
        wait_states = WW'(w);
        while (!done && n < 12) begin
            @(negedge clk);
            n++;
            wait_states = WW'(3 - w);   // R6: later changes must not matter
            if (ext_rd || ext_wr) saw_ext = 1'b1;
            if (int_rd || int_wr) saw_int = 1'b1;
            if (cpu_ready) begin
                done = 1'b1;
                got = int'(cpu_rdata);
            end
        end
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        if (c == 1) check(n == exp_n, "R3 length", n, exp_n);
        else        check(n == exp_n, "R6 length", n, exp_n);
        if (c == 0) check(!saw_int, "R2 no internal strobe", int'(saw_int), 0);
        else        check(saw_int, "R3/R4/R5 internal strobe", int'(saw_int), 1);
        if (c == 1) check(!saw_ext, "R3 no external strobe", int'(saw_ext), 0);
        else        check(saw_ext, "R2/R4/R5 external strobe", int'(saw_ext), 1);
        if (!is_wr) begin
            int e = (c == 0) ? int'(exp_ext[a]) : int'(exp_int[a]);
            if (c == 2) check(got == e, "R4 overlap read data", got, e);
            else        check(got == e, "R7 read data", got, e);
        end
        @(negedge clk);
        check(!cpu_ready, "R9 single ready", int'(cpu_ready), 0);
        if (is_wr) begin
            if (c != 0) exp_int[a] = DW'(d);
            if (c != 1) exp_ext[a] = DW'(d);
            check(int_mem[a] == exp_int[a], "R5 internal contents",
                  int'(int_mem[a]), int'(exp_int[a]));
            check(ext_mem[a] == exp_ext[a], "R5 external contents",
                  int'(ext_mem[a]), int'(exp_ext[a]));
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            exp_int[i] = DW'(i) ^ 8'hA5;
            exp_ext[i] = DW'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R1: quiet during reset with a request pending
        cpu_rd = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !int_rd && !int_wr && !ext_rd && !ext_wr,
              "R1 reset quiet", int'(cpu_ready), 0);
        cpu_rd = 1'b0;
        preload = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !int_rd && !int_wr && !ext_rd && !ext_wr,
              "R1 after reset", int'(cpu_ready), 0);
        // Reads of preloaded contents, then writes and read-back.
        for (int w = 0; w < 4; w++) begin
            for (int a = 0; a < DEPTH; a++)
                run_access(1'b0, a, 0, w);
            for (int a = 0; a < DEPTH; a++)
                run_access(1'b1, a, (a * 7 + w * 61 + 3) & 8'hFF, w);
            for (int a = 0; a < DEPTH; a++)
                run_access(1'b0, a, 0, (w + a) & 3);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule